// File: doc/BRIEF.md
# Serial Register-Access Master

This block runs one register transaction at a time over a four-wire serial link. The four wires are a serial clock, a data line out, a data line in and an active-low strobe. A host pulses `start` together with a direction flag, an 8-bit register address and, for writes, a 32-bit word. The engine then shifts the frame out, most significant bit first, and raises `done` for one cycle when it finishes. After a read, `rdata` holds the 32 bits collected from the data-in line.

The two directions use different frame orders. A write sends the data word first, then the address, then a single command bit of 1. A read sends the address, then a command bit of 0, and then clocks 32 more times to collect the reply. The command bit is the only bit framed by the strobe. The bit rate is set per transaction: each half of every serial bit lasts `half_cycles+1` system clocks. The value is captured when `start` is accepted.

Top module: `serial_reg_master`

## Requirements
- R1: After reset and between transactions, `sclk` is 0, `strobe_n` is 1, `sdo` is 0, `busy` is 0, `done` is 0 and `rdata` is 0.
- R2: A write (`wr`=1) produces exactly 41 rising `sclk` edges. At each rising edge `sdo` carries, in order: `wdata[31]` down to `wdata[0]`, then `addr[7]` down to `addr[0]`, then the command bit 1.
- R3: A read (`wr`=0) produces exactly 41 rising `sclk` edges. At each rising edge `sdo` carries, in order: `addr[7]` down to `addr[0]`, then the command bit 0, then 0 for the 32 read clocks. `sdi` is sampled at the end of each read clock's high half, and the first sampled bit lands in `rdata[31]`.
- R4: `strobe_n` is 0 at the rising edge of the command bit and at no other rising edge. It falls while `sclk` is low, and it rises on the same system clock in which the command bit's `sclk` falls.
- R5: `sdo` changes only while `sclk` is low. It is set at the start of each low half and is stable through the high half.
- R6: Each low half and each high half lasts `half_cycles+1` system clocks. Consecutive rising `sclk` edges are therefore 2·(`half_cycles`+1) system clocks apart.
- R7: A `start` pulse that arrives while `busy` is 1 is ignored. The transaction in progress keeps its frame and its length, and no second transaction follows it.
- R8: `done` is high for exactly one system clock per transaction. `rdata` changes only in a cycle in which `done` is high, and only at the end of a read, so it holds its value through later writes and through idle time.
- R9: After `done`, `sdo` is 0 and `busy` is 0. `busy` is 1 from the cycle after `start` is accepted until `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction (one-cycle pulse) |
| wr | input | 1 | 1 = write, 0 = read; sampled with start |
| addr | input | 8 | Register address, sampled with start |
| wdata | input | 32 | Write word, sampled with start |
| half_cycles | input | 8 | Half-bit length minus one, in system clocks |
| sdi | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock, rests low |
| sdo | output | 1 | Serial data to the slave |
| strobe_n | output | 1 | Active-low command strobe, rests high |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Data collected by the last read |

## Verification
The properties assume that `sdi` is stable at the system clock edge that ends each read clock's high half. The stimulus meets this with a slave model that changes `sdi` only after a falling `sclk` edge. The properties also assume that `start` is a single-cycle pulse. The bench drives it for one cycle, away from the active edge, and its only overlapping start is deliberately issued while `busy` is high to exercise R7. `half_cycles` is kept small so that every frame stays short, and the value is only presented together with `start`.

// File: rtl/srm_pkg.sv
package srm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_SHIFT_DATA = 3'd1,
    ST_SHIFT_ADDR = 3'd2,
    ST_CMD        = 3'd3,
    ST_READ       = 3'd4,
    ST_DONE       = 3'd5
  } srm_state_t;
endpackage

// File: rtl/srm_half_timer.sv
module srm_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] count;

  assign tick = run && (count == limit);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) count <= '0;
    else                     count <= count + 1'b1;
  end
endmodule

// File: rtl/srm_tx_shift.sv
module srm_tx_shift #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sr;

  assign msb = sr[W-1];

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (load)  sr <= load_val;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end
endmodule

// File: rtl/srm_rx_shift.sv
module srm_rx_shift #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         shift,
  input  logic         bit_in,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst || clear) value <= '0;
    else if (shift)   value <= {value[W-2:0], bit_in};
  end
endmodule

// File: rtl/serial_reg_master.sv
module serial_reg_master
  import srm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DIV_W-1:0]  half_cycles,
  input  logic              sdi,
  output logic              sclk,
  output logic              sdo,
  output logic              strobe_n,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(DATA_W + 1);

  srm_state_t       st;
  logic             phase_hi;
  logic [CNT_W-1:0] bits_left;
  logic             wr_q;
  logic [DIV_W-1:0] half_q;
  logic             tick;
  logic             accept;
  logic             end_of_bit;
  logic             tx_shift;
  logic             tx_msb;
  logic             rx_shift;
  logic [DATA_W-1:0] rx_val;
  logic [FRAME_W-1:0] frame;

  assign accept     = (st == ST_IDLE) && start;
  assign end_of_bit = tick && phase_hi;
  assign busy       = (st != ST_IDLE);
  // first bit goes straight to sdo, the shifter holds the remaining bits
  assign frame      = (wr ? {wdata, addr} : {addr, {DATA_W{1'b0}}}) << 1;
  assign tx_shift   = end_of_bit &&
                      ((st == ST_SHIFT_DATA) ||
                       ((st == ST_SHIFT_ADDR) && (bits_left != '0)));
  assign rx_shift   = end_of_bit && (st == ST_READ);

  srm_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .run   (busy),
    .limit (half_q),
    .tick  (tick)
  );

  srm_tx_shift #(.W(FRAME_W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (frame),
    .shift    (tx_shift),
    .msb      (tx_msb)
  );

  srm_rx_shift #(.W(DATA_W)) u_rx (
    .clk    (clk),
    .rst    (rst),
    .clear  (accept),
    .shift  (rx_shift),
    .bit_in (sdi),
    .value  (rx_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      phase_hi  <= 1'b0;
      bits_left <= '0;
      wr_q      <= 1'b0;
      half_q    <= '0;
      sclk      <= 1'b0;
      sdo       <= 1'b0;
      strobe_n  <= 1'b1;
      done      <= 1'b0;
      rdata     <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            wr_q     <= wr;
            half_q   <= half_cycles;
            phase_hi <= 1'b0;
            if (wr) begin
              st        <= ST_SHIFT_DATA;
              bits_left <= CNT_W'(DATA_W - 1);
              sdo       <= wdata[DATA_W-1];
            end else begin
              st        <= ST_SHIFT_ADDR;
              bits_left <= CNT_W'(ADDR_W - 1);
              sdo       <= addr[ADDR_W-1];
            end
          end
        end
        ST_DONE: begin
          sdo  <= 1'b0;
          done <= 1'b1;
          if (!wr_q) rdata <= rx_val;
          st <= ST_IDLE;
        end
        default: begin
          if (tick && !phase_hi) begin
            phase_hi <= 1'b1;
            sclk     <= 1'b1;
          end else if (end_of_bit) begin
            phase_hi <= 1'b0;
            sclk     <= 1'b0;
            case (st)
              ST_SHIFT_DATA: begin
                sdo <= tx_msb;
                if (bits_left == '0) begin
                  st        <= ST_SHIFT_ADDR;
                  bits_left <= CNT_W'(ADDR_W - 1);
                end else begin
                  bits_left <= bits_left - 1'b1;
                end
              end
              ST_SHIFT_ADDR: begin
                if (bits_left == '0) begin
                  st       <= ST_CMD;
                  sdo      <= wr_q;
                  strobe_n <= 1'b0;
                end else begin
                  sdo       <= tx_msb;
                  bits_left <= bits_left - 1'b1;
                end
              end
              ST_CMD: begin
                strobe_n <= 1'b1;
                if (wr_q) begin
                  st <= ST_DONE;
                end else begin
                  st        <= ST_READ;
                  bits_left <= CNT_W'(DATA_W - 1);
                  sdo       <= 1'b0;
                end
              end
              ST_READ: begin
                if (bits_left == '0) st <= ST_DONE;
                else                 bits_left <= bits_left - 1'b1;
              end
              default: st <= ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/srm_checker.sv
module srm_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              sclk,
  input logic              sdo,
  input logic              strobe_n,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] rdata
);
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!sclk && strobe_n)); // R1

  AST_STRB_FALL_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe_n) |-> !sclk); // R4

  AST_STRB_RISE_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe_n) |-> $fell(sclk)); // R4

  AST_SDO_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(sdo)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(rdata) |-> done); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !sdo)); // R9
endmodule

bind serial_reg_master srm_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sclk     (sclk),
  .sdo      (sdo),
  .strobe_n (strobe_n),
  .busy     (busy),
  .done     (done),
  .rdata    (rdata)
);

// File: tb/sim_serial_reg_master.sv
`timescale 1ns/1ps
module sim_serial_reg_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  half_cycles = '0;
  logic        sdi;
  logic        sclk, sdo, strobe_n, busy, done;
  logic [31:0] rdata;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  serial_reg_master u0 (
    .clk(clk), .rst(rst), .start(start), .wr(wr), .addr(addr),
    .wdata(wdata), .half_cycles(half_cycles), .sdi(sdi),
    .sclk(sclk), .sdo(sdo), .strobe_n(strobe_n), .busy(busy),
    .done(done), .rdata(rdata)
  );

  // slave model
  logic [63:0] lb, ls;
  int          nbits;
  int          rise_t0, rise_t1;
  logic        rmode, first;
  logic [5:0]  rcount;
  logic [31:0] resp;

  always @(posedge sclk) begin
    lb = {lb[62:0], sdo};
    ls = {ls[62:0], strobe_n};
    if (nbits == 0) rise_t0 = cyc;
    if (nbits == 1) rise_t1 = cyc;
    nbits++;
    if (!strobe_n && !sdo) begin
      rmode = 1'b1; first = 1'b1; rcount = '0;
    end
  end

  always @(negedge sclk) begin
    if (rmode) begin
      if (first) first = 1'b0;
      else if (rcount < 6'd32) rcount = rcount + 6'd1;
    end
  end

  assign sdi = (rmode && rcount < 6'd32) ? resp[5'd31 - rcount[4:0]] : 1'b1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start(input logic w, input logic [7:0] h,
                             input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = w; half_cycles = h; addr = a; wdata = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin seen = 1'b1; break; end
    end
  endtask

  task automatic run_and_check(input logic w, input logic [7:0] h,
                               input logic [7:0] a, input logic [31:0] d);
    bit seen;
    logic [40:0] exp_b, exp_s;
    lb = '0; ls = '0; nbits = 0; rmode = 1'b0; resp = d;
    pulse_start(w, h, a, d);
    chk(busy == 1'b1, "R9 busy after start", {63'd0, busy}, 64'd1);
    wait_done(seen);
    chk(seen, "R8 done seen", {63'd0, seen}, 64'd1);
    chk(!busy && !sdo && !sclk && strobe_n, "R9 lines at done",
        {60'd0, busy, sdo, sclk, strobe_n}, 64'd1);
    if (w) begin
      exp_b = {d, a, 1'b1};
      exp_s = ~(41'd1);
    end else begin
      exp_b = {a, 1'b0, 32'd0};
      exp_s = ~(41'd1 << 32);
    end
    chk(nbits == 41, w ? "R2 clock count" : "R3 clock count", 64'(nbits), 64'd41);
    chk(lb[40:0] == exp_b, w ? "R2 write frame" : "R3 read frame",
        {23'd0, lb[40:0]}, {23'd0, exp_b});
    chk(ls[40:0] == exp_s, "R4 strobe window", {23'd0, ls[40:0]}, {23'd0, exp_s});
    chk(rise_t1 - rise_t0 == 2 * (int'(h) + 1), "R6 bit period",
        64'(rise_t1 - rise_t0), 64'(2 * (int'(h) + 1)));
    if (!w) chk(rdata == d, "R3 read data", {32'd0, rdata}, {32'd0, d});
    @(negedge clk);
    chk(!done, "R8 done one cycle", {63'd0, done}, 64'd0);
  endtask

  // {wr, half[2:0], addr, data}
  localparam logic [43:0] VEC [0:5] = '{
    {1'b1, 3'd0, 8'h80, 32'h0000_0001},
    {1'b0, 3'd0, 8'hFF, 32'hDEAD_BEEF},
    {1'b1, 3'd2, 8'h02, 32'hA5A5_5A5A},
    {1'b0, 3'd1, 8'h08, 32'h8000_0001},
    {1'b1, 3'd3, 8'h00, 32'hFFFF_FFFF},
    {1'b0, 3'd5, 8'h5A, 32'h1234_5678}
  };

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] keep;
    bit seen;
    lb = '0; ls = '0; nbits = 0; rmode = 1'b0; first = 1'b0;
    rcount = '0; resp = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!sclk && strobe_n && !sdo && !busy && !done && rdata == 0,
        "R1 reset state", {59'd0, sclk, strobe_n, sdo, busy, done}, 64'h8);

    for (int i = 0; i < 6; i++)
      run_and_check(VEC[i][43], {5'd0, VEC[i][42:40]}, VEC[i][39:32], VEC[i][31:0]);

    // R8: rdata holds through a write
    keep = rdata;
    run_and_check(1'b1, 8'd1, 8'h33, 32'h0F0F_0F0F);
    chk(rdata == keep, "R8 rdata held over write", {32'd0, rdata}, {32'd0, keep});

    // R7: start while busy is ignored
    lb = '0; ls = '0; nbits = 0; rmode = 1'b0; resp = '0;
    pulse_start(1'b1, 8'd1, 8'hC3, 32'h1357_9BDF);
    repeat (10) @(negedge clk);
    pulse_start(1'b0, 8'd0, 8'h11, 32'h0);
    wr = 1'b0; addr = '0; wdata = '0;
    wait_done(seen);
    chk(seen && nbits == 41, "R7 length kept", 64'(nbits), 64'd41);
    chk(lb[40:0] == {32'h1357_9BDF, 8'hC3, 1'b1}, "R7 frame kept",
        {23'd0, lb[40:0]}, {23'd0, 32'h1357_9BDF, 8'hC3, 1'b1});
    repeat (60) @(negedge clk);
    chk(nbits == 41 && !busy, "R7 no second frame", 64'(nbits), 64'd41);
    chk(!sclk && strobe_n && !sdo, "R1 idle lines", {61'd0, sclk, strobe_n, sdo}, 64'd2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule